// File: doc/BRIEF.md
# Two-Button Seconds Stopwatch with Lap Freeze

This block is a seconds stopwatch that counts from 00 to 59 and then wraps. It is operated by two raw push-button levels. The run button starts the count from the cleared state, pauses a running count and resumes a paused count. The lap button acts in one of two ways, depending on the state:

- While the watch runs, it freezes the shown value. The internal count keeps advancing, and each further lap press loads a fresh snapshot.
- While the watch is paused, it clears the count.

A run press while the display is frozen does not pause. It returns the display to live tracking.

Each button passes through a two-flop synchroniser and a debounce filter. Only the debounced rising edge counts as a press. A prescaler divides the system clock down to a one-second tick. The prescaler advances only while running, so a pause keeps the fraction of a second already counted. The count is held as two BCD digits. The tens and units digits, plus a frozen flag, feed an external segment decoder.

Top module: `lapwatch_top`

## Requirements
- R1: After synchronous reset the display shows 00, `disp_frozen` is 0 and the watch is stopped, so the digits do not change until a press.
- R2: A run-button press from the stopped state starts counting. The count advances by one second on every TICK_DIV-th clock edge spent running.
- R3: A run-button press while running with a live display pauses the count. A further run press resumes from the held value, including the partial prescaler count, without clearing.
- R4: The count is kept as BCD, with units from 0 to 9 and tens from 0 to 5. After 59 it wraps to 00 and keeps running.
- R5: A lap press while running with a live display sets `disp_frozen` and holds the shown digits at the count present when the press was acted on. The internal count keeps advancing.
- R6: A lap press while frozen loads the current internal count into the shown digits, and `disp_frozen` stays 1.
- R7: A run press while frozen clears `disp_frozen` and returns the display to the live count. The count keeps running and is not paused.
- R8: A lap press while paused clears the count and the prescaler to zero.
- R9: When run and lap presses are recognised in the same cycle, only the run press acts and the lap press is dropped.
- R10: A press is recognised only after the synchronised level has been high for DEB_CYCLES consecutive cycles. A shorter pulse is ignored, and a held button yields exactly one press.
- R11: Whenever `disp_frozen` is 0, including while paused, the digits show the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_run_raw | input | 1 | Raw level of the start/pause/resume button |
| btn_lap_raw | input | 1 | Raw level of the freeze/refresh/clear button |
| disp_tens | output | 4 | BCD tens digit shown (0 to 5) |
| disp_units | output | 4 | BCD units digit shown (0 to 9) |
| disp_frozen | output | 1 | 1 when the digits hold a snapshot instead of the live count |

## Verification
The assertions check the following on every cycle:

- The BCD digit ranges and the wrap from 59 to 00.
- The fact that a frozen display implies a running count.
- The stillness of a frozen snapshot, and of a paused count, when no press occurs.
- The clear on a lap press while paused.
- The precedence of the run press when both buttons are pressed together.
- The single-cycle nature of a press event.

The bench's scenarios are the only way to show the rest. They cover the end-to-end timing from a raw button level to the acted press, the tick arithmetic across pauses and resumes, the snapshot values taken on freeze and refresh, the rejection of short glitches, and the absence of repeated presses while a button is held. In those scenarios every shown digit is compared against a count of running clock edges.

// File: rtl/lapwatch_pkg.sv
package lapwatch_pkg;

    typedef struct packed {
        logic [3:0] tens;
        logic [3:0] units;
    } bcd_sec_t;

    localparam bcd_sec_t BCD_ZERO = '{tens: 4'd0, units: 4'd0};

    // One-second increment in BCD, wrapping 59 -> 00
    function automatic bcd_sec_t bcd_sec_next(input bcd_sec_t v);
        bcd_sec_t r;
        r = v;
        if (v.units == 4'd9) begin
            r.units = 4'd0;
            r.tens  = (v.tens == 4'd5) ? 4'd0 : v.tens + 4'd1;
        end else begin
            r.units = v.units + 4'd1;
        end
        return r;
    endfunction

endpackage

// File: rtl/lw_button_cond.sv
module lw_button_cond #(
    parameter int DEB_CYCLES = 500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic press
);
    localparam int CW = $clog2(DEB_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          level;
        logic [CW-1:0] cnt;
    } cond_t;

    cond_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        press   = 1'b0;
        st_d.s1 = raw;
        st_d.s2 = st_q.s1;
        if (st_q.s2 != st_q.level) begin
            if (st_q.cnt == LAST) begin
                st_d.level = st_q.s2;
                st_d.cnt   = '0;
                press      = st_q.s2;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R10: a press is a single-cycle event
    assert_single_press_R10: assert property (@(posedge clk) disable iff (rst)
        press |=> !press);

endmodule

// File: rtl/lw_tick_gen.sv
module lw_tick_gen #(
    parameter int TICK_DIV = 50_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clr,
    output logic tick
);
    localparam int CW = $clog2(TICK_DIV + 1);
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_t;

    pre_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
        end else if (run) begin
            if (st_q.cnt == LAST) begin
                st_d.cnt = '0;
                tick     = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R3: the partial second is kept while paused
    assert_prescale_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!run && !clr) |=> $stable(st_q.cnt));

endmodule

// File: rtl/lw_bcd_counter.sv
module lw_bcd_counter
    import lapwatch_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     clr,
    output bcd_sec_t value
);
    typedef struct packed {
        bcd_sec_t val;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr)       st_d.val = BCD_ZERO;
        else if (tick) st_d.val = bcd_sec_next(st_q.val);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{val: BCD_ZERO};
        else     st_q <= st_d;
    end

    assign value = st_q.val;

    assert_bcd_range_R4: assert property (@(posedge clk) disable iff (rst)
        (st_q.val.units <= 4'd9) && (st_q.val.tens <= 4'd5));

    assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr && st_q.val.tens == 4'd5 && st_q.val.units == 4'd9)
        |=> (st_q.val.tens == 4'd0 && st_q.val.units == 4'd0));

endmodule

// File: rtl/lapwatch_top.sv
module lapwatch_top
    import lapwatch_pkg::*;
#(
    parameter int TICK_DIV   = 50_000_000,
    parameter int DEB_CYCLES = 500_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       btn_run_raw,
    input  logic       btn_lap_raw,
    output logic [3:0] disp_tens,
    output logic [3:0] disp_units,
    output logic       disp_frozen
);
    localparam int NUM_BTN = 2;
    localparam int IDX_RUN = 0;
    localparam int IDX_LAP = 1;

    typedef struct packed {
        logic     running;
        logic     frozen;
        bcd_sec_t snap;
    } ctl_t;

    logic [NUM_BTN-1:0] raw_vec, press_vec;
    logic     ev_run, ev_lap, clr, tick;
    bcd_sec_t count, shown;
    ctl_t     st_d, st_q;

    assign raw_vec[IDX_RUN] = btn_run_raw;
    assign raw_vec[IDX_LAP] = btn_lap_raw;

    for (genvar i = 0; i < NUM_BTN; i++) begin : g_btn
        lw_button_cond #(.DEB_CYCLES(DEB_CYCLES)) u_cond (
            .clk   (clk),
            .rst   (rst),
            .raw   (raw_vec[i]),
            .press (press_vec[i])
        );
    end

    lw_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (st_q.running),
        .clr  (clr),
        .tick (tick)
    );

    lw_bcd_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .clr   (clr),
        .value (count)
    );

    // Run press wins; a same-cycle lap press is dropped
    assign ev_run = press_vec[IDX_RUN];
    assign ev_lap = press_vec[IDX_LAP] && !press_vec[IDX_RUN];

    always_comb begin
        st_d = st_q;
        clr  = 1'b0;
        if (ev_run) begin
            if (st_q.frozen) st_d.frozen  = 1'b0;
            else             st_d.running = !st_q.running;
        end else if (ev_lap) begin
            if (st_q.running) begin
                st_d.frozen = 1'b1;
                st_d.snap   = count;
            end else begin
                clr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{running: 1'b0, frozen: 1'b0, snap: BCD_ZERO};
        else     st_q <= st_d;
    end

    assign shown       = st_q.frozen ? st_q.snap : count;
    assign disp_tens   = shown.tens;
    assign disp_units  = shown.units;
    assign disp_frozen = st_q.frozen;

    assert_frozen_runs_R7: assert property (@(posedge clk) disable iff (rst)
        st_q.frozen |-> st_q.running);

    assert_frozen_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q.frozen && !press_vec[IDX_RUN] && !press_vec[IDX_LAP])
        |=> (st_q.frozen && $stable(st_q.snap)));

    assert_pause_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!st_q.running && !press_vec[IDX_LAP]) |=> $stable(count));

    assert_pause_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (!st_q.running && press_vec[IDX_LAP] && !press_vec[IDX_RUN])
        |=> (count == BCD_ZERO));

    assert_run_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (press_vec[IDX_RUN] && press_vec[IDX_LAP] && !st_q.frozen)
        |=> (st_q.running != $past(st_q.running) && !st_q.frozen));

endmodule

// File: tb/sim_lapwatch_top.sv
module sim_lapwatch_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 8;
    localparam int DEB = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic b_run = 1'b0, b_lap = 1'b0;
    logic [3:0] d_tens, d_units;
    logic d_frozen;

    int checks = 0, fails = 0;
    bit done = 0, mon_en = 0;
    bit m_run = 0, m_frozen = 0;
    int m_snap = 0, m_edges = 0;
    string cur_req = "R1";

    lapwatch_top #(.TICK_DIV(DIV), .DEB_CYCLES(DEB)) u0 (
        .clk(clk), .rst(rst), .btn_run_raw(b_run), .btn_lap_raw(b_lap),
        .disp_tens(d_tens), .disp_units(d_units), .disp_frozen(d_frozen)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Running-edge count: the live value is floor(edges / DIV) mod 60
    always @(posedge clk) if (!rst && m_run) m_edges = m_edges + 1;

    task automatic check(input string req, input int exp_sec, input bit exp_frz);
        int got;
        got = d_tens * 10 + d_units;
        checks++;
        if (got != exp_sec || d_frozen != exp_frz || d_units > 9 || d_tens > 5) begin
            fails++;
            $display("FAIL %s: shown %0d%0d frozen %0b, expected %0d frozen %0b",
                     req, d_tens, d_units, d_frozen, exp_sec, exp_frz);
        end
    endtask

    function automatic int live_sec();
        return (m_edges / DIV) % 60;
    endfunction

    always begin
        @(posedge clk);
        #1;
        if (mon_en) check(cur_req, m_frozen ? m_snap : live_sec(), m_frozen);
    end

    task automatic press(input bit a, input bit b, input string tag);
        bit e0, e1;
        mon_en = 0;
        cur_req = tag;
        @(negedge clk);
        b_run = a; b_lap = b;
        repeat (DEB + 2) @(posedge clk);
        @(negedge clk);
        e0 = a; e1 = b && !a;
        if (e0) begin
            if (m_frozen) m_frozen = 0;
            else          m_run = !m_run;
        end else if (e1) begin
            if (m_run) begin
                m_frozen = 1;
                m_snap = ((m_edges - 1) / DIV) % 60;
            end else begin
                m_edges = 0;
            end
        end
        mon_en = 1;
        repeat (DEB + 4) @(negedge clk);   // held: must not repeat (R10)
        b_run = 0; b_lap = 0;
        repeat (DEB + 6) @(negedge clk);
    endtask

    task automatic idle(input int n, input string tag);
        cur_req = tag;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1", 0, 0);
        mon_en = 1;
        idle(30, "R1");
        press(1, 0, "R2");      idle(50, "R2");
        press(1, 0, "R3");      idle(40, "R3 R11");
        press(1, 0, "R3");      idle(30, "R3");
        press(0, 1, "R5");      idle(40, "R5");
        press(0, 1, "R6");      idle(40, "R6");
        press(1, 0, "R7");      idle(20, "R7 R11");
        press(0, 1, "R5");      idle(10, "R5");
        press(1, 1, "R9");      idle(20, "R9");   // frozen: unfreeze only
        press(1, 1, "R9");      idle(20, "R9");   // live: pause only
        press(0, 1, "R8");      idle(20, "R8");
        @(negedge clk);
        check("R8", 0, 0);
        // glitches shorter than the debounce window are ignored
        cur_req = "R10";
        @(negedge clk); b_run = 1; b_lap = 1;
        repeat (2) @(negedge clk); b_run = 0; b_lap = 0;
        idle(30, "R10");
        check("R10", 0, 0);
        press(1, 0, "R4");      idle(60 * DIV + 60, "R4");
        @(negedge clk); b_lap = 1;
        repeat (DEB - 1) @(negedge clk); b_lap = 0;
        idle(30, "R10");
        mon_en = 0;
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule